// File: doc/BRIEF.md
# Drift-Compensated Nanosecond Timer with Periodic Pulses

This block keeps a 64-bit nanosecond time value for packet timestamping. It runs from a reference clock that is faster than the nominal tick rate. A 32-bit phase accumulator adds a programmable fractional addend on every reference cycle. Only the cycles on which that addition carries out of 32 bits count as ticks, and each tick advances the time value by a programmable tick period. Software sets the addend to about 2^32 times the nominal-to-reference frequency ratio, rounded up, and trims it to correct for drift without stopping the clock.

The same tick stream drives two further parts. A prescaler makes a divided output clock. Two interval generators produce periodic pulses; one is usually set to one pulse per second. Each interval value is programmed one tick period short of the full interval, so a value of (N-1) times the tick period gives one pulse every N ticks. Each pulse lasts one period of the divided output clock. Configuration and loading of the time value use a single-cycle write port.

Top module: `drift_ns_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the accumulator, time value, prescaler phase, pulse counters and all configuration registers clear to zero. After reset, `time_ns` is 0 and `out_clk`, `pulse_a` and `pulse_b` are low.
- R2: On each cycle the accumulator adds the addend modulo 2^32, starting from 0 after reset. A cycle whose addition carries out of bit 31 is a tick. At the next edge a tick adds the tick period to `time_ns`; with no tick `time_ns` holds. For example, an addend of 0x80000000 gives a tick on every second cycle.
- R3: A new addend is used from the cycle after its write. The write does not clear the accumulator. An addend of 0 stops the time value.
- R4: Writing address 5 loads `wr_data` into `time_ns` at that edge. The load takes priority over a tick in the same cycle, and the accumulator keeps running.
- R5: An interval generator with a nonzero value V = (N-1)·P, where P is the tick period, fires on every N-th tick after its last restart.
- R6: A firing raises the pulse in the next cycle. The pulse then stays high for max(prescale,1) ticks. A new firing while the pulse is high restarts that width.
- R7: An interval generator whose value is 0 never fires, so its pulse never rises.
- R8: Writing address 5, or writing a generator's own interval address, restarts that generator: its countdown reloads from its interval value and its pulse drops at the next edge.
- R9: The prescaler phase counts ticks modulo the prescale value, and a write of the prescale value clears it. `out_clk` is high while the phase is below floor(prescale/2), so a prescale below 2 keeps it low.
- R10: A write takes effect when `wr_en` is high at a clock edge. The low bits of `wr_data` are used, and `wr_addr` selects the target: 0 addend (32 bits), 1 tick period (8 bits), 2 prescale (16 bits), 3 interval A (32 bits), 4 interval B (32 bits), 5 time value (64 bits). A new tick period is used for ticks after the edge that writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 3 | Target register select |
| wr_data | input | 64 | Write data; low bits used for narrow registers |
| time_ns | output | 64 | Current time in nanoseconds |
| out_clk | output | 1 | Divided output clock |
| pulse_a | output | 1 | Periodic pulse from interval generator A |
| pulse_b | output | 1 | Periodic pulse from interval generator B |

## Verification
A load of the time value can land in the same cycle as an accumulator carry. In that cycle the load must win outright, and the tick period must not be added on top. The bench provokes this with an addend that ticks every other cycle and back-to-back time writes, so one of the two writes is sure to meet a tick. A behavioural model, compared on every clock, judges the result. Interval restarts that fall on a firing tick are exercised the same way: interval writes arrive while the pulses run.

// File: rtl/dnt_pkg.sv
// Shared definitions for the drift-compensated nanosecond timer.
// Holds the write-address map used by the register write path.
package dnt_pkg;
    typedef enum logic [2:0] {
        ADR_ADDEND   = 3'd0,
        ADR_PERIOD   = 3'd1,
        ADR_PRESCALE = 3'd2,
        ADR_IVAL_A   = 3'd3,
        ADR_IVAL_B   = 3'd4,
        ADR_TIME     = 3'd5
    } dnt_addr_e;
endpackage

// File: rtl/dnt_phase_acc.sv
// Fractional phase accumulator. Adds the addend on every reference cycle
// and flags a tick on each carry out of the top bit.
// Assumes the addend is already registered by the caller.
module dnt_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] addend,
    output logic             tick
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    // Full-width sum, with the carry kept as the extra bit
    always_comb begin
        sum  = {1'b0, acc_q} + {1'b0, addend};
        tick = sum[ACC_W];
    end

    // Keep the fractional remainder each cycle
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= sum[ACC_W-1:0];
    end
endmodule

// File: rtl/dnt_prescaler.sv
// Tick-driven prescaler: counts ticks modulo the prescale value and makes
// a divided clock that is high for the lower half of the count.
// Assumes the prescale value only changes together with a clear.
module dnt_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    input  logic [PSC_W-1:0] prescale,
    output logic             out_clk
);
    logic [PSC_W-1:0] phase_q;
    logic [PSC_W:0]   phase_inc;

    // Next phase value before the wrap
    always_comb phase_inc = {1'b0, phase_q} + 1'b1;

    // Advance the phase on ticks and wrap at the prescale value
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            phase_q <= '0;
        else if (tick)
            phase_q <= (phase_inc >= {1'b0, prescale}) ? '0 : phase_inc[PSC_W-1:0];
    end

    // High in the lower half of each divided period
    always_comb out_clk = (phase_q < (prescale >> 1));

    // R9: the phase never reaches the prescale value
    p_phase_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (prescale != '0) |-> (phase_q < prescale));
endmodule

// File: rtl/dnt_interval_gen.sv
// Fixed-interval pulse generator. Counts down by the tick period on each
// tick, fires when less than one period remains, reloads, and stretches
// each firing into a pulse lasting max(prescale,1) ticks.
// Assumes an interval value of 0 means the generator is idle.
module dnt_interval_gen #(
    parameter int IVAL_W = 32,
    parameter int PER_W  = 8,
    parameter int PSC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              restart,
    input  logic [IVAL_W-1:0] reload_val,
    input  logic [IVAL_W-1:0] interval,
    input  logic [PER_W-1:0]  period,
    input  logic [PSC_W-1:0]  prescale,
    output logic              pulse
);
    logic [IVAL_W-1:0] cnt_q;
    logic [PSC_W-1:0]  hold_q;
    logic [IVAL_W-1:0] per_ext;
    logic              active;
    logic              fire;

    // Firing decision for this cycle
    always_comb begin
        per_ext = {{(IVAL_W-PER_W){1'b0}}, period};
        active  = (interval != '0);
        fire    = tick && !restart && active && (cnt_q < per_ext);
    end

    // Countdown with reload on firing or restart
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= reload_val;
        else if (tick && active)
            cnt_q <= (cnt_q < per_ext) ? interval : cnt_q - per_ext;
    end

    // Pulse width counter measured in ticks
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            hold_q <= '0;
        else if (fire)
            hold_q <= (prescale == '0) ? PSC_W'(1) : prescale;
        else if (tick && hold_q != '0)
            hold_q <= hold_q - 1'b1;
    end

    always_comb pulse = (hold_q != '0);

    // R6: a firing is visible on the pulse in the next cycle
    p_fire_raises_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> pulse);
    // R8: a restart drops the pulse
    p_restart_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !pulse);
    // R7: an idle generator cannot raise its pulse
    p_idle_no_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !restart) |=> !$rose(pulse));
endmodule

// File: rtl/drift_ns_timer.sv
// Drift-compensated nanosecond timer. Holds the configuration registers and
// the 64-bit time value, and feeds the accumulator tick to the prescaler and
// to the two interval generators.
// Assumes one write per cycle; writes take effect at the edge that samples them.
module drift_ns_timer #(
    parameter int TIME_W = 64,
    parameter int ACC_W  = 32,
    parameter int PER_W  = 8,
    parameter int PSC_W  = 16,
    parameter int IVAL_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [TIME_W-1:0] wr_data,
    output logic [TIME_W-1:0] time_ns,
    output logic              out_clk,
    output logic              pulse_a,
    output logic              pulse_b
);
    import dnt_pkg::*;

    localparam int NUM_GEN = 2;

    logic [ACC_W-1:0]  addend_q;
    logic [PER_W-1:0]  period_q;
    logic [PSC_W-1:0]  prescale_q;
    logic [IVAL_W-1:0] ival_q [NUM_GEN];
    logic [TIME_W-1:0] time_q;
    logic              tick;
    logic              wr_time;
    logic              wr_psc;
    logic [NUM_GEN-1:0] wr_ival;
    logic [NUM_GEN-1:0] gen_pulse;

    // Decode the write strobe per target
    always_comb begin
        wr_time    = wr_en && (wr_addr == ADR_TIME);
        wr_psc     = wr_en && (wr_addr == ADR_PRESCALE);
        wr_ival[0] = wr_en && (wr_addr == ADR_IVAL_A);
        wr_ival[1] = wr_en && (wr_addr == ADR_IVAL_B);
    end

    // Scalar configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addend_q   <= '0;
            period_q   <= '0;
            prescale_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADR_ADDEND) addend_q   <= wr_data[ACC_W-1:0];
            if (wr_addr == ADR_PERIOD) period_q   <= wr_data[PER_W-1:0];
            if (wr_psc)                prescale_q <= wr_data[PSC_W-1:0];
        end
    end

    // Time value: a load wins over a tick in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            time_q <= '0;
        else if (wr_time)
            time_q <= wr_data;
        else if (tick)
            time_q <= time_q + {{(TIME_W-PER_W){1'b0}}, period_q};
    end

    assign time_ns = time_q;

    dnt_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .addend (addend_q),
        .tick   (tick)
    );

    dnt_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clear    (wr_psc),
        .prescale (prescale_q),
        .out_clk  (out_clk)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_ival
        logic              restart;
        logic [IVAL_W-1:0] reload;

        // Restart source and the value reloaded on restart
        always_comb begin
            restart = wr_time || wr_ival[g];
            reload  = wr_ival[g] ? wr_data[IVAL_W-1:0] : ival_q[g];
        end

        // Interval register for this generator
        always_ff @(posedge clk) begin
            if (!rst_n)          ival_q[g] <= '0;
            else if (wr_ival[g]) ival_q[g] <= wr_data[IVAL_W-1:0];
        end

        dnt_interval_gen #(.IVAL_W(IVAL_W), .PER_W(PER_W), .PSC_W(PSC_W)) u_gen (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick),
            .restart    (restart),
            .reload_val (reload),
            .interval   (ival_q[g]),
            .period     (period_q),
            .prescale   (prescale_q),
            .pulse      (gen_pulse[g])
        );
    end

    assign pulse_a = gen_pulse[0];
    assign pulse_b = gen_pulse[1];

    // R2: without a tick or a load the time value holds
    p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_time) |=> $stable(time_ns));
    // R2: a tick advances the time value by the tick period
    p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_time) |=> (time_ns == $past(time_ns) + TIME_W'($past(period_q))));
    // R4: a load is taken exactly, whatever the accumulator did
    p_time_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_time |=> (time_ns == $past(wr_data)));
endmodule

// File: tb/drift_ns_timer_bench.sv
// Bench: a behavioural model updated on each rising edge and compared on
// each falling edge, plus directed window checks derived from the requirements.
module drift_ns_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] time_ns;
    logic        out_clk, pulse_a, pulse_b;

    int checks = 0;
    int fails  = 0;
    bit run_cmp = 1'b0;
    bit done = 1'b0;

    drift_ns_timer u_drift_ns_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .time_ns(time_ns), .out_clk(out_clk),
        .pulse_a(pulse_a), .pulse_b(pulse_b)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Behavioural model state
    longint unsigned m_acc, m_time, m_add, m_per, m_psc, m_pc;
    longint unsigned m_ival [2];
    longint unsigned m_cnt  [2];
    longint unsigned m_hold [2];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = 0; m_time = 0; m_add = 0; m_per = 0; m_psc = 0; m_pc = 0;
            for (int k = 0; k < 2; k++) begin m_ival[k] = 0; m_cnt[k] = 0; m_hold[k] = 0; end
        end else begin
            longint unsigned s;
            bit tk;
            s  = m_acc + m_add;
            tk = (s >= 64'h1_0000_0000);
            m_acc = s & 64'hFFFF_FFFF;
            if (wr_en && wr_addr == 3'd5) m_time = wr_data;
            else if (tk) m_time = m_time + m_per;
            for (int k = 0; k < 2; k++) begin
                bit rs;
                rs = wr_en && (wr_addr == 3'd5 || wr_addr == 3'(3 + k));
                if (rs) begin
                    m_cnt[k]  = (wr_en && wr_addr == 3'(3 + k)) ? (wr_data & 64'hFFFF_FFFF) : m_ival[k];
                    m_hold[k] = 0;
                end else if (tk && m_ival[k] != 0) begin
                    if (m_cnt[k] < m_per) begin
                        m_cnt[k]  = m_ival[k];
                        m_hold[k] = (m_psc == 0) ? 1 : m_psc;
                    end else begin
                        m_cnt[k] = m_cnt[k] - m_per;
                        if (m_hold[k] != 0) m_hold[k] = m_hold[k] - 1;
                    end
                end else if (tk && m_hold[k] != 0) begin
                    m_hold[k] = m_hold[k] - 1;
                end
            end
            if (wr_en && wr_addr == 3'd2) m_pc = 0;
            else if (tk) m_pc = (m_pc + 1 >= m_psc) ? 0 : m_pc + 1;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_add  = wr_data & 64'hFFFF_FFFF;
                    3'd1: m_per  = wr_data & 64'hFF;
                    3'd2: m_psc  = wr_data & 64'hFFFF;
                    3'd3: m_ival[0] = wr_data & 64'hFFFF_FFFF;
                    3'd4: m_ival[1] = wr_data & 64'hFFFF_FFFF;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input string what, input longint unsigned got,
                       input longint unsigned exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && run_cmp && !done) begin
            chk("R2/R4/R10", "time_ns", time_ns, m_time);
            chk("R9", "out_clk", out_clk, (m_pc < (m_psc >> 1)) ? 1 : 0);
            chk("R5/R6/R8", "pulse_a", pulse_a, m_hold[0] != 0);
            chk("R5/R7/R8", "pulse_b", pulse_b, m_hold[1] != 0);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        @(posedge clk); #5;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #5;
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        longint unsigned t0;
        int rises, highs, bhigh;
        bit prev;
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "time_ns", time_ns, 0);
        chk("R1", "out_clk", out_clk, 0);
        chk("R1", "pulse_a", pulse_a, 0);
        chk("R1", "pulse_b", pulse_b, 0);
        run_cmp = 1'b1;

        wr(3'd1, 64'd10);
        wr(3'd2, 64'd4);
        wr(3'd3, 64'd40);           // 5 ticks per pulse
        wr(3'd4, 64'd0);
        wr(3'd0, 64'h8000_0000);    // tick every second cycle
        repeat (20) @(posedge clk);

        // R2: 10 cycles hold exactly 5 ticks
        @(negedge clk); t0 = time_ns;
        repeat (10) @(negedge clk);
        chk("R2", "time step over 10 cycles", time_ns - t0, 50);

        // R5, R6, R7: pulse counts over 100 cycles
        @(negedge clk); prev = pulse_a; rises = 0; highs = 0; bhigh = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (pulse_a && !prev) rises++;
            if (pulse_a) highs++;
            if (pulse_b) bhigh++;
            prev = pulse_a;
        end
        chk("R5", "pulse_a rises", rises, 10);
        chk("R6", "pulse_a high cycles", highs, 80);
        chk("R7", "pulse_b high cycles", bhigh, 0);

        // R9: out_clk duty over 40 cycles
        highs = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (out_clk) highs++;
        end
        chk("R9", "out_clk high cycles", highs, 20);

        // R3: addend 0 freezes, then a quarter addend ticks 1 in 4
        wr(3'd0, 64'd0);
        @(negedge clk); t0 = time_ns;
        repeat (10) @(negedge clk);
        chk("R3", "time with zero addend", time_ns - t0, 0);
        wr(3'd0, 64'h4000_0000);
        @(negedge clk); t0 = time_ns;
        repeat (16) @(negedge clk);
        chk("R3", "time with quarter addend", time_ns - t0, 40);

        // R10: new tick period
        wr(3'd0, 64'h8000_0000);
        wr(3'd1, 64'd20);
        @(negedge clk); t0 = time_ns;
        repeat (10) @(negedge clk);
        chk("R10", "time step with period 20", time_ns - t0, 100);

        // R4, R8: time load and restart
        wr(3'd5, 64'd1000);
        @(negedge clk);
        chk("R4", "loaded time", time_ns, 1000);
        chk("R8", "pulse_a after load", pulse_a, 0);
        // Back-to-back loads: one meets a tick
        @(posedge clk); #5; wr_en = 1'b1; wr_addr = 3'd5; wr_data = 64'd5000;
        @(posedge clk); #5; wr_data = 64'd7000;
        @(posedge clk); #5; wr_en = 1'b0;
        @(negedge clk);
        chk("R4", "second back-to-back load", time_ns, 7000);

        // R8: interval write while pulses run
        wr(3'd3, 64'd60);
        repeat (17) @(posedge clk);
        wr(3'd3, 64'd20);
        @(negedge clk);
        chk("R8", "pulse_a after interval write", pulse_a, 0);

        // Larger addend, prescale change and second generator active
        wr(3'd0, 64'h9999_99A4);
        wr(3'd1, 64'd10);
        wr(3'd2, 64'd3);
        wr(3'd4, 64'd30);
        repeat (300) @(posedge clk);
        wr(3'd2, 64'd1);
        repeat (100) @(posedge clk);
        @(negedge clk);
        chk("R9", "out_clk with prescale 1", out_clk, 0);
        finish_run();
    end
endmodule